// File: doc/BRIEF.md
# Bipolar-Extending Serial ADC Read Sequencer

This controller obtains a signed 11-bit sample from a 10-bit converter that only measures one direction across a differential channel pair. After a start request it runs three chip-select frames over a mode-0 serial link. The converter returns the data for the configuration it received in the previous frame. So the first frame only loads a configuration, and its returned data is thrown away. The second frame returns the forward reading. The third frame returns the reverse reading.

Whichever reading is nonzero carries the sample. A nonzero forward reading gives a positive result. When the forward reading is zero, the reverse reading is negated instead. The value is presented left-justified in a 16-bit two's-complement word. It comes with a one-cycle done strobe. Zero is reachable from both readings, so the 1024 codes of each direction combine into 2047 distinct results.

Top module: `bipolar_adc_seq`

## Requirements
- R1: While reset is high and after it is released, chip select is high, the serial clock is low, busy and done are low, and the result is 0.
- R2: Every run sends three frames. The first transmitted byte of each frame is, in order, 0x7F (forward, unipolar, MSB-first, 16-bit word), then 0x3F (reverse, same options), then 0x7F again. The second transmitted byte of each frame is 0x00.
- R3: Each frame holds chip select low for exactly 16 serial-clock rising edges. The serial clock idles low whenever chip select is high.
- R4: The input line is sampled on the rising serial-clock edge, most significant bit first. The first byte received is the high byte. The word received in the first frame is discarded. The second frame's word is the forward reading, and the third frame's word is the reverse reading.
- R5: Between consecutive frames of a run, chip select stays high for at least GAP_CYCLES clock cycles.
- R6: If the forward reading is nonzero, the result equals that reading shifted right by one bit with 0 entering at bit 15.
- R7: If the forward reading is zero, the result equals the two's-complement negation of the reverse reading shifted right by one bit. The negation inverts all 16 bits and adds 1, with the carry running across the whole word.
- R8: For converter words whose low six bits are zero, the result carries the sign in bit 15 and magnitude bits B10..B0 in bits 15..5, and bits 4..0 are zero.
- R9: A start pulse while busy is high has no effect. It adds no frames and no extra done pulse.
- R10: Done is high for exactly one cycle, on the cycle the result changes. Done arrives 96*HALF_DIV + 2*GAP_CYCLES cycles after the start edge, and the result holds between done pulses.
- R11: A reset in the middle of a run returns the link to idle, and the next run begins again with the configuration-only frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a three-frame run when idle |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle strobe when the result updates |
| result | output | 16 | Left-justified signed sample |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Configuration data to the converter |
| miso | input | 1 | Conversion data from the converter |

## Verification
Each frame takes 32*HALF_DIV cycles and each inter-frame gap takes GAP_CYCLES cycles. The result and its strobe are therefore due exactly 96*HALF_DIV + 2*GAP_CYCLES cycles after the edge that captures start. The bench counts cycles from that edge and checks the strobe lands on that exact cycle. The bench also compares the result on the falling clock edge of the strobe cycle, so the registered value is settled when it is read. Configuration bytes, bit counts and gap lengths are captured by a converter model on the serial edges themselves. They are checked once chip select rises, which happens before the strobe is sampled.

// File: rtl/bipolar_adc_seq.sv
module bipolar_adc_seq #(
  parameter int HALF_DIV = 2,
  parameter int GAP_CYCLES = 24,
  parameter logic [7:0] CFG_FWD = 8'h7F,
  parameter logic [7:0] CFG_REV = 8'h3F
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic [15:0] result,
  output logic        cs_n,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  localparam int DIVW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int GAPW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} state_t;

  state_t            st;
  logic [1:0]        frame;
  logic [3:0]        bitcnt;
  logic [DIVW-1:0]   divcnt;
  logic [GAPW-1:0]   gapcnt;
  logic [15:0]       tx, rx, fwd;
  logic [15:0]       fwd_half, rev_half, resolved;

  assign busy     = (st != S_IDLE);
  assign mosi     = tx[15];
  assign fwd_half = {1'b0, fwd[15:1]};
  assign rev_half = {1'b0, rx[15:1]};
  assign resolved = (fwd != 16'd0) ? fwd_half : (~rev_half + 16'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      frame  <= '0;
      bitcnt <= '0;
      divcnt <= '0;
      gapcnt <= '0;
      tx     <= '0;
      rx     <= '0;
      fwd    <= '0;
      result <= '0;
      done   <= 1'b0;
      cs_n   <= 1'b1;
      sclk   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            st     <= S_SHIFT;
            cs_n   <= 1'b0;
            frame  <= '0;
            tx     <= {CFG_FWD, 8'h00};
            bitcnt <= '0;
            divcnt <= '0;
          end
        end
        S_SHIFT: begin
          if (divcnt == DIVW'(HALF_DIV - 1)) begin
            divcnt <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
              rx   <= {rx[14:0], miso};
            end else begin
              sclk   <= 1'b0;
              tx     <= {tx[14:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
              if (bitcnt == 4'd15) begin
                cs_n <= 1'b1;
                case (frame)
                  2'd0: st <= S_GAP;
                  2'd1: begin
                    fwd <= rx;
                    st  <= S_GAP;
                  end
                  default: begin
                    result <= resolved;
                    done   <= 1'b1;
                    st     <= S_IDLE;
                  end
                endcase
              end
            end
          end else begin
            divcnt <= divcnt + DIVW'(1);
          end
        end
        S_GAP: begin
          if (gapcnt == GAPW'(GAP_CYCLES - 1)) begin
            gapcnt <= '0;
            st     <= S_SHIFT;
            cs_n   <= 1'b0;
            frame  <= frame + 2'd1;
            tx     <= {(frame == 2'd0) ? CFG_REV : CFG_FWD, 8'h00};
            bitcnt <= '0;
            divcnt <= '0;
          end else begin
            gapcnt <= gapcnt + GAPW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bipolar_adc_seq_chk.sv
module bipolar_adc_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [15:0] result,
  input logic        cs_n,
  input logic        sclk
);
  assert_idle_cs_high_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n);

  assert_sclk_low_deselected_R3: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !busy);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_ends_run_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !done |=> (done || $stable(result)));
endmodule

bind bipolar_adc_seq bipolar_adc_seq_chk u_chk (.*);

// File: tb/tb_bipolar_adc_seq.sv
module tb_bipolar_adc_seq;
  localparam int HALF_DIV = 2;
  localparam int GAP = 24;
  localparam int RUN_CYC = 96 * HALF_DIV + 2 * GAP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic miso = 1'b0;
  logic busy, done, cs_n, sclk, mosi;
  logic [15:0] result;

  always #2 clk = ~clk;

  bipolar_adc_seq #(.HALF_DIV(HALF_DIV), .GAP_CYCLES(GAP)) dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .result(result), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso));

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] word_q[$];
  logic [7:0]  cfg_log[$];
  logic [7:0]  low_log[$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Converter model
  logic [15:0] s_sr, s_in;
  int s_bits;
  always @(negedge cs_n) begin
    s_sr = (word_q.size() != 0) ? word_q.pop_front() : 16'hA5A5;
    miso = s_sr[15];
    s_bits = 0;
    s_in = 16'h0;
  end
  always @(posedge sclk) if (!cs_n) begin
    s_in = {s_in[14:0], mosi};
    s_bits++;
  end
  always @(negedge sclk) if (!cs_n) begin
    s_sr = {s_sr[14:0], 1'b0};
    miso = s_sr[15];
  end
  always @(posedge cs_n) if (!rst) begin
    check(s_bits == 16, "R3", s_bits, 16);
    cfg_log.push_back(s_in[15:8]);
    low_log.push_back(s_in[7:0]);
  end

  // Monitor: scoreboard pop and gap measurement
  int gapc = 0;
  always @(negedge clk) if (!rst) begin
    if (done) begin
      if (exp_q.size() == 0) check(1'b0, "R10", result, 0);
      else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(result == e, t, result, e);
        check(result[4:0] == 5'd0, "R8", result[4:0], 0);
      end
    end
    if (busy && cs_n) gapc++;
    else if (!cs_n && gapc > 0) begin
      check(gapc >= GAP, "R5", gapc, GAP);
      gapc = 0;
    end else if (!busy) gapc = 0;
  end

  task automatic run_pair(input logic [15:0] fw, input logic [15:0] rv, input bit extra_start);
    logic [15:0] e;
    int cyc;
    if (fw != 16'h0) e = fw >> 1;
    else e = 16'h0 - (rv >> 1);
    word_q.push_back(16'hDEAD);
    word_q.push_back(fw);
    word_q.push_back(rv);
    exp_q.push_back(e);
    tag_q.push_back((fw != 16'h0) ? "R6" : "R7");
    cfg_log.delete();
    low_log.delete();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (extra_start && cyc == 40) start = 1'b1;
      if (extra_start && cyc == 41) start = 1'b0;
    end while (!done);
    check(cyc == RUN_CYC, "R10", cyc, RUN_CYC);
    @(negedge clk);
    check(!done, "R10", done, 0);
    check(cfg_log.size() == 3, "R2", cfg_log.size(), 3);
    if (cfg_log.size() == 3) begin
      check(cfg_log[0] == 8'h7F, "R2", cfg_log[0], 8'h7F);
      check(cfg_log[1] == 8'h3F, "R2", cfg_log[1], 8'h3F);
      check(cfg_log[2] == 8'h7F, "R2", cfg_log[2], 8'h7F);
      check(low_log[0] == 8'h00 && low_log[1] == 8'h00 && low_log[2] == 8'h00,
            "R2", low_log[1], 0);
    end
    repeat (20) @(negedge clk);
    check(result == e, "R10", result, e);
    if (extra_start) begin
      repeat (150) @(negedge clk);
      check(!busy, "R9", busy, 0);
      check(cfg_log.size() == 3, "R9", cfg_log.size(), 3);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n === 1'b1 && sclk === 1'b0, "R1", {cs_n, sclk}, 2'b10);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n === 1'b1 && sclk === 1'b0, "R1", {cs_n, sclk}, 2'b10);
    check(busy === 1'b0 && done === 1'b0, "R1", {busy, done}, 0);
    check(result === 16'h0, "R1", result, 0);

    run_pair(16'hFFC0, 16'h0000, 1'b0);  // R6 full-scale positive
    run_pair(16'h0000, 16'hFFC0, 1'b0);  // R7 full-scale negative
    run_pair(16'h0000, 16'h0000, 1'b0);  // R7 zero from both
    run_pair(16'h0040, 16'h0000, 1'b0);  // R6 smallest positive
    run_pair(16'h0000, 16'h0040, 1'b0);  // R7 smallest negative
    run_pair(16'h4000, 16'h8000, 1'b0);  // R4 forward wins, high byte first
    run_pair(16'h0000, 16'h0AC0, 1'b1);  // R9 extra start while busy

    // R11: reset in the middle of a run
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (100) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(cs_n && !sclk && !busy, "R11", {cs_n, sclk, busy}, 3'b100);
    word_q.delete();
    rst = 1'b0;
    run_pair(16'h1240, 16'h0000, 1'b0);
    check(cfg_log.size() != 0 && cfg_log[0] == 8'h7F, "R11",
          (cfg_log.size() != 0) ? cfg_log[0] : 0, 8'h7F);
    check(exp_q.size() == 0, "R10", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule